// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a 16-bit Accumulator Machine

This block is the control unit of a small accumulator processor, built as a micro-programmed sequencer instead of a hardwired state machine. A 4-bit micro-address register selects one word of a 13-entry control store. Each word carries the datapath control points for the current cycle, a next-address field and a 2-bit branch type. The branch type chooses where the sequencer goes next. It can go through an opcode dispatch table, to the word's own next-address field, or to a target that depends on the sign bit of the accumulator.

The datapath drives the block with the 5-bit opcode field of the instruction register and with bit 15 of the accumulator. The block returns the ALU operation, the memory operation, the program-counter controls, the register load enables and the data-bus drive. Every output is a combinational decode of the current control word, and the ALU operation also uses the opcode. The state encodings, and the control sequence for every instruction, are the same as in the equivalent hardwired controller.

Top module: `useq_ctrl`

## Requirements
- R1: With `rst` high at a rising edge, the micro-address becomes 0000 at that edge (reset1). In that word `pc_sel` is 01 and every other control output is 0.
- R2: A word whose branch type is 01 moves to its own next-address field. reset1 goes to reset2, and reset2 goes to fetch (0010). In reset2 `pc_sel`=10, `pc_inc_sel`=1 and `ao_ld`=1. aopr, sopr, store2, load3, brn2 and jump go back to fetch. store1 goes to store2, load1 goes to load2, and load2 goes to load3.
- R3: The fetch word has branch type 00, so it dispatches on the opcode: 0000x goes to sopr (0100), 0011x to aopr (0011), 00100 to store1 (0101), 00101 to load1 (1000), 00010 to brn1 (1011) and 00011 to jump (1101).
- R4: From fetch, any opcode whose upper two bits are not 00 dispatches to reset1 (0000).
- R5: brn1 (1011) goes to brn2 (1100) when `ac_sign` is 1 and to fetch when it is 0. In brn1 `pc_sel`=10, `pc_inc_sel`=1 and `ao_ld`=1.
- R6: fetch drives `mem_op`=01 (read), `pc_sel`=11 and `di_ld`=1, with everything else 0.
- R7: aopr drives `alu_op`=010 (AND) for opcode 00110 and 011 (ADD) for 00111. It also drives `ac_ld`=1, `pc_sel`=10, `pc_inc_sel`=1 and `ao_ld`=1.
- R8: sopr drives `alu_op`=001 (NOT) for opcode 00000 and 100 (shift right) for 00001, with the same register controls as aopr.
- R9: store1 drives `pc_sel`=11, `ao_sel`=1 and `ao_ld`=1. store2 drives `mem_op`=10 (write), `bus_drv`=1, `pc_sel`=10, `pc_inc_sel`=1 and `ao_ld`=1.
- R10: load1 drives the same controls as store1, and load2 the same controls as fetch. load3 drives `alu_op`=000 (pass A), `ac_ld`=1, `pc_sel`=10, `pc_inc_sel`=1 and `ao_ld`=1.
- R11: brn2 (1100) and jump (1101) drive `pc_sel`=10, `pc_inc_sel`=0, `ao_sel`=1 and `ao_ld`=1.
- R12: The outputs change in the same cycle as the micro-address, with no register between the control store and the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 5 | Opcode field of the instruction register |
| ac_sign | input | 1 | Accumulator bit 15 |
| alu_op | output | 3 | ALU operation code |
| mem_op | output | 2 | Memory operation: 00 none, 01 read, 10 write |
| pc_sel | output | 2 | Program-counter mux select |
| pc_inc_sel | output | 1 | Program-counter input select |
| di_ld | output | 1 | Data-in register load |
| ac_ld | output | 1 | Accumulator load |
| ao_sel | output | 1 | Address-out register source select |
| ao_ld | output | 1 | Address-out register load |
| bus_drv | output | 1 | Accumulator drive onto the data bus |

## Verification
The bench steps a behavioural model of the hardwired transition table next to the design and compares every output on every cycle. It changes the opcode only in fetch, as a real instruction register would. The conditional branch is hit with both sign values. A design that swapped the test would fall through to fetch when it should take brn2, or the other way round. Undefined opcodes and resets in the middle of an instruction are also injected. A sequencer that decoded only the low opcode bits would wrongly start an execute sequence. One that registered its outputs would lag the model by a cycle. The ALU code in aopr and sopr is checked against the opcode's low bit. A design that took the ALU code only from the control word would get one of each pair wrong.

// File: rtl/useq_ctrl.sv
module useq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] opcode,
  input  logic       ac_sign,
  output logic [2:0] alu_op,
  output logic [1:0] mem_op,
  output logic [1:0] pc_sel,
  output logic       pc_inc_sel,
  output logic       di_ld,
  output logic       ac_ld,
  output logic       ao_sel,
  output logic       ao_ld,
  output logic       bus_drv
);
  localparam int AW   = 4;
  localparam int BRW  = 2;
  localparam int ALUW = 3;
  localparam int MW   = 2;
  localparam int PSW  = 2;
  localparam int FLW  = 6;
  localparam int CWW  = AW + BRW + ALUW + MW + PSW + FLW;

  localparam logic [AW-1:0] S_RST1 = 4'd0,  S_RST2 = 4'd1,  S_FETCH = 4'd2,
                            S_AOPR = 4'd3,  S_SOPR = 4'd4,  S_ST1   = 4'd5,
                            S_ST2  = 4'd6,  S_LD1  = 4'd8,  S_LD2   = 4'd9,
                            S_LD3  = 4'd10, S_BRN1 = 4'd11, S_BRN2  = 4'd12,
                            S_JMP  = 4'd13;
  localparam logic [1:0] B_MAP = 2'b00, B_NEXT = 2'b01, B_COND = 2'b11;
  localparam logic [2:0] ALU_FROM_OP = 3'b111;

  // flags: {pc_inc_sel, di_ld, ac_ld, ao_sel, ao_ld, bus_drv}
  function automatic logic [CWW-1:0] cw(input logic [AW-1:0] nx, input logic [1:0] br,
                                        input logic [2:0] alu, input logic [1:0] mem,
                                        input logic [1:0] ps, input logic [5:0] fl);
    return {nx, br, alu, mem, ps, fl};
  endfunction

  function automatic logic [CWW-1:0] ustore(input logic [AW-1:0] a);
    case (a)
      S_RST1:  return cw(S_RST2,  B_NEXT, 3'b000,      2'b00, 2'b01, 6'b000000);
      S_RST2:  return cw(S_FETCH, B_NEXT, 3'b000,      2'b00, 2'b10, 6'b100010);
      S_FETCH: return cw(S_RST1,  B_MAP,  3'b000,      2'b01, 2'b11, 6'b010000);
      S_AOPR:  return cw(S_FETCH, B_NEXT, ALU_FROM_OP, 2'b00, 2'b10, 6'b101010);
      S_SOPR:  return cw(S_FETCH, B_NEXT, ALU_FROM_OP, 2'b00, 2'b10, 6'b101010);
      S_ST1:   return cw(S_ST2,   B_NEXT, 3'b000,      2'b00, 2'b11, 6'b000110);
      S_ST2:   return cw(S_FETCH, B_NEXT, 3'b000,      2'b10, 2'b10, 6'b100011);
      S_LD1:   return cw(S_LD2,   B_NEXT, 3'b000,      2'b00, 2'b11, 6'b000110);
      S_LD2:   return cw(S_LD3,   B_NEXT, 3'b000,      2'b01, 2'b11, 6'b010000);
      S_LD3:   return cw(S_FETCH, B_NEXT, 3'b000,      2'b00, 2'b10, 6'b101010);
      S_BRN1:  return cw(S_BRN2,  B_COND, 3'b000,      2'b00, 2'b10, 6'b100010);
      S_BRN2:  return cw(S_FETCH, B_NEXT, 3'b000,      2'b00, 2'b10, 6'b000110);
      S_JMP:   return cw(S_FETCH, B_NEXT, 3'b000,      2'b00, 2'b10, 6'b000110);
      default: return cw(S_RST1,  B_NEXT, 3'b000,      2'b00, 2'b00, 6'b000000);
    endcase
  endfunction

  function automatic logic [AW-1:0] dispatch(input logic [4:0] op);
    casez (op)
      5'b0000?: return S_SOPR;
      5'b0011?: return S_AOPR;
      5'b00100: return S_ST1;
      5'b00101: return S_LD1;
      5'b00010: return S_BRN1;
      5'b00011: return S_JMP;
      default:  return S_RST1;
    endcase
  endfunction

  function automatic logic [2:0] op_alu(input logic [2:0] low);
    case (low)
      3'b000:  return 3'b001;
      3'b001:  return 3'b100;
      3'b110:  return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  logic [AW-1:0]  upc, upc_nx, w_next;
  logic [CWW-1:0] word;
  logic [1:0]     w_br;
  logic [2:0]     w_alu;

  assign word = ustore(upc);
  assign {w_next, w_br, w_alu, mem_op, pc_sel, pc_inc_sel, di_ld, ac_ld, ao_sel, ao_ld, bus_drv} = word;
  assign alu_op = (w_alu == ALU_FROM_OP) ? op_alu(opcode[2:0]) : w_alu;

  always_comb begin
    case (w_br)
      B_MAP:   upc_nx = dispatch(opcode);
      B_COND:  upc_nx = ac_sign ? w_next : S_FETCH;
      default: upc_nx = w_next;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= S_RST1;
    else     upc <= upc_nx;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (upc == S_RST1 && pc_sel == 2'b01 && !ao_ld));
  p_aopr_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (upc == S_FETCH && opcode[4:1] == 4'b0011) |=> (upc == S_AOPR));
  p_undef_op_r4: assert property (@(posedge clk) disable iff (rst)
    (upc == S_FETCH && opcode[4:3] != 2'b00) |=> (upc == S_RST1));
  p_brn_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (upc == S_BRN1 && ac_sign) |=> (upc == S_BRN2));
  p_brn_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (upc == S_BRN1 && !ac_sign) |=> (upc == S_FETCH && mem_op == 2'b01));
  p_write_drives_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 2'b10) |-> (bus_drv && $past(ao_sel)));
  p_jump_no_inc_r11: assert property (@(posedge clk) disable iff (rst)
    (upc == S_JMP) |=> (upc == S_FETCH && di_ld));
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] opcode = 5'd0;
  logic       ac_sign = 1'b0;
  logic [2:0] alu_op;
  logic [1:0] mem_op, pc_sel;
  logic       pc_inc_sel, di_ld, ac_ld, ao_sel, ao_ld, bus_drv;

  useq_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .ac_sign(ac_sign),
    .alu_op(alu_op), .mem_op(mem_op), .pc_sel(pc_sel), .pc_inc_sel(pc_inc_sel),
    .di_ld(di_ld), .ac_ld(ac_ld), .ao_sel(ao_sel), .ao_ld(ao_ld), .bus_drv(bus_drv)
  );

  always #10 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 0;
  int    st = 0;
  string arrival = "R1";

  function automatic int ref_next(int s, logic [4:0] op, logic sgn);
    case (s)
      0: return 1;
      1: return 2;
      2: begin
        if (op[4:3] != 2'b00) return 0;
        case (op[2:0])
          3'd0, 3'd1: return 4;
          3'd6, 3'd7: return 3;
          3'd4: return 5;
          3'd5: return 8;
          3'd2: return 11;
          default: return 13;
        endcase
      end
      5: return 6;
      8: return 9;
      9: return 10;
      11: return sgn ? 12 : 2;
      default: return 2;
    endcase
  endfunction

  function automatic logic [12:0] ref_out(int s, logic [4:0] op);
    logic [2:0] alu = 0; logic [1:0] mem = 0, ps = 0;
    logic inc = 0, di = 0, ac = 0, asel = 0, ald = 0, drv = 0;
    case (s)
      0: ps = 2'b01;
      1: begin ps = 2'b10; inc = 1; ald = 1; end
      2, 9: begin mem = 2'b01; ps = 2'b11; di = 1; end
      3: begin alu = op[0] ? 3'b011 : 3'b010; ps = 2'b10; inc = 1; ac = 1; ald = 1; end
      4: begin alu = op[0] ? 3'b100 : 3'b001; ps = 2'b10; inc = 1; ac = 1; ald = 1; end
      5, 8: begin ps = 2'b11; asel = 1; ald = 1; end
      6: begin mem = 2'b10; ps = 2'b10; inc = 1; ald = 1; drv = 1; end
      10: begin ps = 2'b10; inc = 1; ac = 1; ald = 1; end
      11: begin ps = 2'b10; inc = 1; ald = 1; end
      default: begin ps = 2'b10; asel = 1; ald = 1; end
    endcase
    return {alu, mem, ps, inc, di, ac, asel, ald, drv};
  endfunction

  function automatic string content_tag(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5, 6: return "R9";
      8, 9, 10: return "R10";
      11: return "R5";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st <= 0;
      arrival <= "R1";
    end else begin
      st <= ref_next(st, opcode, ac_sign);
      if (st == 2)       arrival <= (opcode[4:3] == 2'b00) ? "R3" : "R4";
      else if (st == 11) arrival <= "R5";
      else               arrival <= "R2";
    end
  end

  task automatic compare();
    logic [12:0] got, exp;
    got = {alu_op, mem_op, pc_sel, pc_inc_sel, di_ld, ac_ld, ao_sel, ao_ld, bus_drv};
    exp = ref_out(st, opcode);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s/%s (R12 same-cycle decode) state=%0d op=%b: got %b expected %b",
               arrival, content_tag(st), st, opcode, got, exp);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) begin @(negedge clk); compare(); end
    rst = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare();
      ac_sign = 1'($urandom);
      if (st == 2 || rst) begin
        if ($urandom % 10 < 8) opcode = {2'b00, 3'($urandom % 8)};
        else                   opcode = 5'($urandom);
      end
      rst = ($urandom % 97 == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule